// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge

This block lets several interrupting devices share a single request line to a processor and settles which of them is served when more than one asks at once. Each device has a stage that keeps a pending flag. The pending flags are ORed into one shared request. When the processor answers with an acknowledge level, that acknowledge passes through the stages in order. The first stage holding a request keeps the acknowledge and puts its service-routine address (its vector) on a shared return bus. Every stage after it sees no acknowledge.

The order of stages in the chain sets the priority. Stage 0 is nearest the processor and always wins over higher-numbered stages. The request pattern is captured when acknowledge first rises and stays fixed while acknowledge is held, so a request that arrives late cannot change the winner halfway through a cycle. The winning stage clears its own pending flag. Any losers stay pending and are served on later acknowledge cycles. Each stage's vector is a parameter.

Top module: `intr_daisy_chain`

## Requirements
- R1: `cpu_irq` is high exactly when at least one stage holds a pending request. It is updated on the same clock edge as the pending flags.
- R2: A request pulse of one cycle or more on `dev_req[i]` sets the pending flag of stage i on the next clock edge. The flag stays set, so `cpu_irq` stays high, until that stage is acknowledged.
- R3: When several stages are pending, the stage with the lowest index receives the acknowledge.
- R4: Suppose `cpu_ack` is first sampled high at clock edge E0. At edge E0+1 the outputs take these values: `vec_bus` holds the winner's vector, `vec_valid` is 1 and `dev_grant` is one-hot at the winner's bit position. The outputs then hold while `cpu_ack` stays high.
- R5: At most one bit of `dev_grant` is ever set. Whenever `vec_valid` is 0, `vec_bus` reads zero.
- R6: The winner is decided from the requests pending when `cpu_ack` rose. A request raised while acknowledge is held does not change `vec_bus` or `dev_grant`. It stays pending and is served on the next acknowledge cycle.
- R7: The winning stage's pending flag clears at edge E0+1. Stages that lost stay pending, and the next acknowledge returns the highest-priority stage still pending.
- R8: Once `cpu_ack` is sampled low, `vec_bus`, `vec_valid` and `dev_grant` return to zero one edge later.
- R9: After synchronous reset, `cpu_irq`, `vec_bus`, `vec_valid` and `dev_grant` are all zero.
- R10: An acknowledge cycle with no stage pending leaves `vec_valid` at 0, `vec_bus` at 0 and `dev_grant` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_DEV | Request from each device; bit 0 is nearest the processor |
| cpu_ack | input | 1 | Acknowledge level from the processor, entering at stage 0 |
| cpu_irq | output | 1 | Shared request to the processor |
| vec_bus | output | VEC_W | Vector of the acknowledged stage, zero when none |
| vec_valid | output | 1 | A stage is driving `vec_bus` |
| dev_grant | output | NUM_DEV | One-hot acknowledge delivered to the winning device |

## Verification
The bench applies several request patterns. A single request shows that the right vector is delivered and that the flag clears. Two simultaneous requests separate correct positional priority from reversed priority, and a second acknowledge on the same pair shows that the loser survived. A request that arrives while acknowledge is held separates a frozen snapshot from a live chain. An acknowledge with nothing pending shows that the bus really reads zero and that no spurious grant is issued.

// File: rtl/dc_pkg.sv
package dc_pkg;
  // Phase of the processor acknowledge as seen by the chain.
  typedef struct packed {
    logic live;   // acknowledge has been sampled high
    logic rise;   // acknowledge is high this cycle but was low last edge
    logic first;  // first cycle in which the chain holds a valid snapshot
  } ack_phase_t;
endpackage

// File: rtl/dc_ack_timing.sv
module dc_ack_timing
  import dc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_ack,
  output ack_phase_t phase
);
  logic ack_d;
  logic ack_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d  <= 1'b0;
      ack_d2 <= 1'b0;
    end else begin
      ack_d  <= cpu_ack;
      ack_d2 <= ack_d;
    end
  end

  always_comb begin
    phase.live  = ack_d;
    phase.rise  = cpu_ack & ~ack_d;
    phase.first = ack_d & ~ack_d2;
  end
endmodule

// File: rtl/dc_stage.sv
module dc_stage
  import dc_pkg::*;
#(
  parameter int              VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             cpu_ack_i,
  input  ack_phase_t       phase_i,
  input  logic             ack_in_i,
  output logic             ack_out_o,
  output logic             take_o,
  output logic [VEC_W-1:0] drive_o,
  output logic             pending_o,
  output logic             pending_next_o
);
  logic pending_q;
  logic frozen_q;
  logic clear;

  // Winner drops its own flag on the first valid acknowledge cycle.
  assign clear          = take_o & phase_i.first;
  assign pending_next_o = (pending_q & ~clear) | req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      frozen_q  <= 1'b0;
    end else begin
      pending_q <= pending_next_o;
      if (!cpu_ack_i)
        frozen_q <= 1'b0;
      else if (phase_i.rise)
        frozen_q <= pending_q;
    end
  end

  assign take_o    = ack_in_i & frozen_q;
  assign ack_out_o = ack_in_i & ~frozen_q;
  assign drive_o   = take_o ? VEC : '0;
  assign pending_o = pending_q;

  // R6: snapshot does not move while acknowledge is held
  p_snapshot_held_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_i.live && $past(phase_i.live)) |-> $stable(frozen_q));

  // R7: a stage that just won and is not re-requesting is no longer pending
  p_winner_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(take_o) && !req_i) |=> !pending_q);
endmodule

// File: rtl/dc_bus_merge.sv
module dc_bus_merge #(
  parameter int NUM_DEV = 4,
  parameter int VEC_W   = 8
) (
  input  logic [NUM_DEV*VEC_W-1:0] drives,
  output logic [VEC_W-1:0]         merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_DEV; i++)
      merged = merged | drives[i*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/intr_daisy_chain.sv
module intr_daisy_chain
  import dc_pkg::*;
#(
  parameter int                       NUM_DEV = 4,
  parameter int                       VEC_W   = 8,
  parameter logic [NUM_DEV*VEC_W-1:0] VECTORS = 32'h4C38_2410
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               cpu_ack,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   vec_bus,
  output logic               vec_valid,
  output logic [NUM_DEV-1:0] dev_grant
);
  localparam int BUS_W = NUM_DEV * VEC_W;

  ack_phase_t           phase;
  logic [NUM_DEV:0]     ack_chain;
  logic [NUM_DEV-1:0]   take;
  logic [NUM_DEV-1:0]   pending;
  logic [NUM_DEV-1:0]   pending_next;
  logic [BUS_W-1:0]     drives;
  logic [VEC_W-1:0]     merged;

  dc_ack_timing u_timing (
    .clk     (clk),
    .rst     (rst),
    .cpu_ack (cpu_ack),
    .phase   (phase)
  );

  assign ack_chain[0] = phase.live;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_stage
    dc_stage #(
      .VEC_W (VEC_W),
      .VEC   (VECTORS[g*VEC_W +: VEC_W])
    ) u_stage (
      .clk            (clk),
      .rst            (rst),
      .req_i          (dev_req[g]),
      .cpu_ack_i      (cpu_ack),
      .phase_i        (phase),
      .ack_in_i       (ack_chain[g]),
      .ack_out_o      (ack_chain[g+1]),
      .take_o         (take[g]),
      .drive_o        (drives[g*VEC_W +: VEC_W]),
      .pending_o      (pending[g]),
      .pending_next_o (pending_next[g])
    );
  end

  dc_bus_merge #(.NUM_DEV(NUM_DEV), .VEC_W(VEC_W)) u_merge (
    .drives (drives),
    .merged (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      vec_bus   <= '0;
      vec_valid <= 1'b0;
      dev_grant <= '0;
    end else begin
      cpu_irq   <= |pending_next;
      vec_bus   <= merged;
      vec_valid <= |take;
      dev_grant <= take;
    end
  end

  // R5: never more than one granted device
  p_single_grant_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_grant));

  // R5: idle bus reads zero
  p_idle_bus_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> (vec_bus == '0));

  // R8: acknowledge seen low empties the outputs one edge later
  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    !phase.live |=> !vec_valid);

  // R1: shared request tracks the stage flags
  p_irq_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    (|pending) |-> cpu_irq);

  // R4: a valid vector comes with a one-hot grant
  p_valid_grant_r4: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $onehot(dev_grant));
endmodule

// File: tb/test_intr_daisy_chain.sv
`timescale 1ns/1ps
module test_intr_daisy_chain;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [W-1:0] V0 = 8'h10, V1 = 8'h24, V2 = 8'h38, V3 = 8'h4C;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] dev_req;
  logic         cpu_ack;
  logic         cpu_irq;
  logic [W-1:0] vec_bus;
  logic         vec_valid;
  logic [N-1:0] dev_grant;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  intr_daisy_chain #(.NUM_DEV(N), .VEC_W(W), .VECTORS({V3, V2, V1, V0})) i_intr_daisy_chain (
    .clk(clk), .rst(rst), .dev_req(dev_req), .cpu_ack(cpu_ack),
    .cpu_irq(cpu_irq), .vec_bus(vec_bus), .vec_valid(vec_valid), .dev_grant(dev_grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    dev_req = m;
    @(negedge clk);
    dev_req = '0;
  endtask

  // raise ack; return at the negedge after edge E0+1
  task automatic ack_on;
    cpu_ack = 1'b1;
    cycles(2);
  endtask

  task automatic ack_off;
    cpu_ack = 1'b0;
    cycles(2);
  endtask

  task automatic t_reset;
    rst = 1'b1; dev_req = '0; cpu_ack = 1'b0;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 irq", cpu_irq, 0);
    chk("R9 bus", vec_bus, 0);
    chk("R9 valid", vec_valid, 0);
    chk("R9 grant", dev_grant, 0);
  endtask

  task automatic t_single;
    pulse_req(4'b0100);
    chk("R1 irq after request", cpu_irq, 1);
    cycles(4);
    chk("R2 request held", cpu_irq, 1);
    ack_on();
    chk("R4 vector", vec_bus, V2);
    chk("R4 grant", dev_grant, 4'b0100);
    chk("R4 valid", vec_valid, 1);
    chk("R7 flag cleared", cpu_irq, 0);
    cycles(2);
    chk("R4 held", vec_bus, V2);
    ack_off();
    chk("R8 bus released", vec_bus, 0);
    chk("R8 valid released", vec_valid, 0);
    chk("R8 grant released", dev_grant, 0);
  endtask

  task automatic t_priority;
    pulse_req(4'b1010);
    ack_on();
    chk("R3 nearest wins", vec_bus, V1);
    chk("R3 grant", dev_grant, 4'b0010);
    chk("R7 loser pending", cpu_irq, 1);
    ack_off();
    ack_on();
    chk("R7 loser served", vec_bus, V3);
    chk("R7 loser grant", dev_grant, 4'b1000);
    chk("R7 all clear", cpu_irq, 0);
    ack_off();
  endtask

  task automatic t_late;
    pulse_req(4'b1000);
    ack_on();
    chk("R6 initial winner", vec_bus, V3);
    pulse_req(4'b0001);
    @(negedge clk);
    chk("R6 bus unchanged", vec_bus, V3);
    chk("R6 grant unchanged", dev_grant, 4'b1000);
    chk("R6 late still pending", cpu_irq, 1);
    ack_off();
    ack_on();
    chk("R6 late served next", vec_bus, V0);
    ack_off();
  endtask

  task automatic t_empty;
    chk("R10 nothing pending", cpu_irq, 0);
    ack_on();
    chk("R10 valid", vec_valid, 0);
    chk("R10 bus", vec_bus, 0);
    chk("R5 no grant", dev_grant, 0);
    ack_off();
  endtask

  initial begin
    t_reset();
    t_single();
    t_priority();
    t_late();
    t_empty();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule